// File: doc/BRIEF.md
# Configurable Chip-Select Gated Register

This block is a single pipeline stage for the command and address path of a memory module. On every rising clock edge it captures a parallel input word and presents it on two output banks. Two mode inputs fix the layout. In the narrow-through layout, all 25 input bits pass one-to-one to the first bank and the second bank stays low. In the fan-out layout, the lowest 14 input bits are copied to both banks. A second mode bit then places the copies either at the bottom of each bank or at the top of each bank.

A pair of active-high select inputs can freeze the stage. When both selects are sampled high at an edge, the outputs keep their previous value. When either select is low, the stage loads normally. Tying the second select low gives a plain register. An asynchronous active-low reset clears every output at once and overrides the freeze. The mode inputs are treated as static and are changed only while reset is held.

Top module: `csGatedRegister`

## Requirements
- R1: While `rstN` is low, both output banks are zero, and they clear as soon as `rstN` falls without waiting for a clock edge.
- R2: With `modeFanout`=0 and the stage not frozen, `qBank1` equals the `dIn` sampled at the previous rising edge (bit i to bit i), and `qBank2` is zero.
- R3: With `modeFanout`=1, `qBank1` and `qBank2` always carry identical values.
- R4: With `modeFanout`=1 and `modeArrB`=0, input bit i (i = 0..13) appears at position i of each bank. Positions 14..24 are zero, and `dIn` bits 14..24 have no effect on the outputs.
- R5: With `modeFanout`=1 and `modeArrB`=1, input bit i (i = 0..13) appears at position i+11 of each bank. Positions 0..10 are zero, and `dIn` bits 14..24 have no effect on the outputs.
- R6: When `selA` and `selB` are both high at a rising edge, neither bank changes at that edge, whatever `dIn` is.
- R7: When either `selA` or `selB` is low at a rising edge, the outputs take the new input word at that edge.
- R8: With `selB` held low, the stage loads on every edge for any value of `selA`.
- R9: Asserting `rstN` low while the stage is frozen still clears both banks.
- R10: After `rstN` rises with `dIn` held at zero, both banks stay zero on every following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeFanout | input | 1 | 0: 25-bit one-to-one layout; 1: 14-bit duplicated layout |
| modeArrB | input | 1 | In duplicated layout: 0 places bits low, 1 places bits high |
| selA | input | 1 | First freeze select (active high) |
| selB | input | 1 | Second freeze select (active high) |
| dIn | input | 25 | Input word |
| qBank1 | output | 25 | First output bank |
| qBank2 | output | 25 | Second output bank |

## Verification
Each layout is driven with walking ones, alternating patterns and all-ones words. Walking ones expose a single misrouted or shifted bit. Setting the upper 11 input bits in the duplicated layouts shows that unused inputs never leak into either bank. Select pairs are swept through all four combinations while the data changes, so a freeze that reacts to only one select shows up. Reset is pulsed mid-cycle during a freeze, and then released with zero inputs, to separate an asynchronous clear from a synchronous one.

// File: rtl/csGatedRegisterPkg.sv
package csGatedRegisterPkg;
  typedef struct packed {
    logic load;     // capture the new word at this edge
    logic fanOut;   // duplicated layout selected
    logic arrHigh;  // duplicated bits placed at the top of each bank
  } regStrobes_t;
endpackage

// File: rtl/csGatedRegisterCtrl.sv
module csGatedRegisterCtrl
  import csGatedRegisterPkg::*;
(
  input  logic        modeFanout,
  input  logic        modeArrB,
  input  logic        selA,
  input  logic        selB,
  output regStrobes_t strobes
);
  always_comb begin
    strobes.load    = !(selA && selB);
    strobes.fanOut  = modeFanout;
    strobes.arrHigh = modeArrB;
  end
endmodule

// File: rtl/csGatedRegisterPath.sv
module csGatedRegisterPath
  import csGatedRegisterPkg::*;
#(
  parameter int WIDTH = 25,
  parameter int HALF  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [WIDTH-1:0]  dIn,
  output logic [WIDTH-1:0]  qBank1,
  output logic [WIDTH-1:0]  qBank2
);
  localparam int OFFSET = WIDTH - HALF;

  logic [WIDTH-1:0] nextBank1;
  logic [WIDTH-1:0] nextBank2;

  for (genvar p = 0; p < WIDTH; p++) begin : gBit
    logic lowSrc;
    logic highSrc;
    logic dupVal;
    if (p < HALF) begin : gLow
      assign lowSrc = dIn[p];
    end else begin : gLowNone
      assign lowSrc = 1'b0;
    end
    if (p >= OFFSET) begin : gHigh
      assign highSrc = dIn[p-OFFSET];
    end else begin : gHighNone
      assign highSrc = 1'b0;
    end
    assign dupVal       = strobes.arrHigh ? highSrc : lowSrc;
    assign nextBank1[p] = strobes.fanOut ? dupVal : dIn[p];
    assign nextBank2[p] = strobes.fanOut ? dupVal : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qBank1 <= '0;
      qBank2 <= '0;
    end else if (strobes.load) begin
      qBank1 <= nextBank1;
      qBank2 <= nextBank2;
    end
  end
endmodule

// File: rtl/csGatedRegister.sv
module csGatedRegister
  import csGatedRegisterPkg::*;
#(
  parameter int WIDTH = 25,
  parameter int HALF  = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeFanout,
  input  logic             modeArrB,
  input  logic             selA,
  input  logic             selB,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qBank1,
  output logic [WIDTH-1:0] qBank2
);
  regStrobes_t strobes;

  csGatedRegisterCtrl uCtrl (
    .modeFanout(modeFanout),
    .modeArrB  (modeArrB),
    .selA      (selA),
    .selB      (selB),
    .strobes   (strobes)
  );

  csGatedRegisterPath #(.WIDTH(WIDTH), .HALF(HALF)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dIn    (dIn),
    .qBank1 (qBank1),
    .qBank2 (qBank2)
  );
endmodule

// File: rtl/csGatedRegisterChecker.sv
module csGatedRegisterChecker #(
  parameter int WIDTH = 25,
  parameter int HALF  = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeFanout,
  input logic             modeArrB,
  input logic             selA,
  input logic             selB,
  input logic [WIDTH-1:0] dIn,
  input logic [WIDTH-1:0] qBank1,
  input logic [WIDTH-1:0] qBank2
);
  localparam int OFFSET = WIDTH - HALF;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (qBank1 == '0 && qBank2 == '0));

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeFanout && !(selA && selB)) |=> (qBank1 == $past(dIn) && qBank2 == '0));

  assert_banks_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeFanout |-> (qBank1 == qBank2));

  assert_arr_low_top_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeFanout && !modeArrB) |-> (qBank1[WIDTH-1:HALF] == '0));

  assert_arr_high_bottom_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeFanout && modeArrB) |-> (qBank1[OFFSET-1:0] == '0));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selA && selB) |=> ($stable(qBank1) && $stable(qBank2)));
endmodule

bind csGatedRegister csGatedRegisterChecker #(.WIDTH(WIDTH), .HALF(HALF)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .modeFanout(modeFanout),
  .modeArrB  (modeArrB),
  .selA      (selA),
  .selB      (selB),
  .dIn       (dIn),
  .qBank1    (qBank1),
  .qBank2    (qBank2)
);

// File: tb/tb_csGatedRegister.sv
`timescale 1ns/1ps
module tb_csGatedRegister;
  localparam int W = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeFanout = 1'b0;
  logic modeArrB = 1'b0;
  logic selA = 1'b0;
  logic selB = 1'b0;
  logic [W-1:0] dIn = '0;
  logic [W-1:0] qBank1;
  logic [W-1:0] qBank2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csGatedRegister dut (
    .clk(clk), .rstN(rstN), .modeFanout(modeFanout), .modeArrB(modeArrB),
    .selA(selA), .selB(selB), .dIn(dIn), .qBank1(qBank1), .qBank2(qBank2)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%07h expected=%07h", req, act, exp);
    end
  endtask

  // Expected banks from the requirement text (R2, R4, R5)
  function automatic logic [W-1:0] expFirst(input logic [W-1:0] d, input logic fan, input logic hi);
    if (!fan) return d;
    if (hi) return {d[13:0], 11'b0};
    return {11'b0, d[13:0]};
  endfunction

  function automatic logic [W-1:0] expSecond(input logic [W-1:0] d, input logic fan, input logic hi);
    if (!fan) return '0;
    return expFirst(d, fan, hi);
  endfunction

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic setMode(input logic fan, input logic hi);
    rstN = 1'b0; #1;
    modeFanout = fan; modeArrB = hi; dIn = '0; selA = 0; selB = 0;
    step();
    rstN = 1'b1;
    step();
  endtask

  task automatic loadAndCheck(input string req, input logic [W-1:0] d);
    dIn = d;
    step();
    check(req, qBank1, expFirst(d, modeFanout, modeArrB));
    check(req, qBank2, expSecond(d, modeFanout, modeArrB));
  endtask

  task automatic testReset;
    check("R1 reset state bank1", qBank1, '0);
    check("R1 reset state bank2", qBank2, '0);
    setMode(0, 0);
    loadAndCheck("R2 load before async reset", 25'h1ABCDEF);
    rstN = 1'b0; #0.5;  // mid-cycle, no edge yet
    check("R1 async clear bank1", qBank1, '0);
    check("R1 async clear bank2", qBank2, '0);
  endtask

  task automatic testDirect;
    setMode(0, 0);
    for (int i = 0; i < W; i += 6) loadAndCheck("R2 walking one", 25'h1 << i);
    loadAndCheck("R2 alternating", 25'h0AAAAAA);
    loadAndCheck("R2 all ones", '1);
  endtask

  task automatic testArrLow;
    setMode(1, 0);
    for (int i = 0; i < 14; i += 4) loadAndCheck("R4 walking one", 25'h1 << i);
    loadAndCheck("R4 upper inputs ignored", 25'h1FFC000);
    loadAndCheck("R4 all ones", '1);
    check("R3 banks identical", qBank1, qBank2);
  endtask

  task automatic testArrHigh;
    setMode(1, 1);
    for (int i = 0; i < 14; i += 4) loadAndCheck("R5 walking one", 25'h1 << i);
    loadAndCheck("R5 upper inputs ignored", 25'h1FFC000);
    loadAndCheck("R5 alternating", 25'h0001555);
    check("R3 banks identical", qBank1, qBank2);
  endtask

  task automatic testSelects;
    logic [W-1:0] held;
    setMode(0, 0);
    loadAndCheck("R7 base load", 25'h0123456);
    held = 25'h0123456;
    selA = 1; selB = 1; dIn = 25'h1FEDCBA;
    step(); step();
    check("R6 frozen bank1", qBank1, held);
    check("R6 frozen bank2", qBank2, '0);
    selA = 1; selB = 0;
    loadAndCheck("R7 selB low loads", 25'h0F0F0F0);
    selA = 0; selB = 1;
    loadAndCheck("R7 selA low loads", 25'h10F0F0F);
    selA = 0; selB = 0;
    loadAndCheck("R7 both low loads", 25'h0055AA5);
  endtask

  task automatic testSelBTied;
    setMode(1, 0);
    selB = 0;
    for (int i = 0; i < 4; i++) begin
      selA = i[0];
      loadAndCheck("R8 selB tied low", 25'h0000777 + (i << 4));
    end
  endtask

  task automatic testResetOverFreeze;
    setMode(0, 0);
    loadAndCheck("R9 preload", 25'h1555555);
    selA = 1; selB = 1;
    step();
    rstN = 1'b0; #0.5;
    check("R9 reset beats freeze bank1", qBank1, '0);
    step();
    check("R9 reset beats freeze bank2", qBank2, '0);
  endtask

  task automatic testRelease;
    rstN = 1'b0; selA = 0; selB = 0; dIn = '0; modeFanout = 0; modeArrB = 0;
    step();
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R10 quiet after release bank1", qBank1, '0);
      check("R10 quiet after release bank2", qBank2, '0);
    end
  endtask

  initial begin
    #1;
    testReset();
    testDirect();
    testArrLow();
    testArrHigh();
    testSelects();
    testSelBTied();
    testResetOverFreeze();
    testRelease();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule